// File: doc/BRIEF.md
# Cascade Bus Role Selector for a Tiered Interrupt Controller

This block sits beside the priority logic of an eight-input interrupt controller and lets several such controllers be chained into a two-tier tree: one master and up to eight slaves, for at most 64 request inputs. A strap input picks the role. The 3-bit cascade bus is split into an input port, an output port and a drive enable, so that the pad ring or the parent can build the bidirectional line from them.

In the master role, a programmable 8-bit attachment mask tells which of its own request inputs are fed by a slave. The acknowledge sequence runs as follows. On the first acknowledge pulse the block latches the acknowledged level from the priority logic. If that level is marked as slave-attached, the master places the level number on the cascade lines and holds it there until the final pulse of the sequence ends. In that case the master keeps its own vector off the data bus. If the level is not slave-attached, the master leaves the cascade lines undriven and enables its own vector during the vector pulses.

In the slave role, the same configuration write stores a 3-bit identity. The slave enables its vector only while an acknowledge pulse that carries a vector is active and the cascade input equals its identity. A sequence has two pulses or three, chosen by a mode input. The first pulse never carries a vector.

Top module: `cas_sel_top`

## Requirements
- R1: While reset is held and in the first cycle after it, cas_oe, cas_out, data_oe and data_out are all zero.
- R2: In the master role, when bit L of the attachment mask is 1 and level L is acknowledged, cas_oe is 1 and cas_out equals L from the cycle after the first ack rise is sampled. Both hold until the cycle after the falling ack of the final pulse is sampled, and data_oe stays 0 throughout.
- R3: In the master role, when bit L of the attachment mask is 0, cas_oe stays 0. During each vector pulse, data_oe is 1 and data_out equals vec_in, one cycle behind ack.
- R4: With long_seq=0 a sequence has two ack pulses and only the second carries a vector. With long_seq=1 it has three pulses, and the second and third carry a vector. No data enable is raised in the first pulse or between pulses.
- R5: In the slave role, during a vector pulse, data_oe is 1 and data_out equals vec_in exactly when cas_in equals the stored 3-bit identity.
- R6: In the slave role, when cas_in differs from the stored identity, data_oe and data_out stay 0 for the whole sequence.
- R7: In the slave role, cas_oe is never 1.
- R8: A cycle with cfg_we=1 loads cfg_data. Bit i is the attachment flag of request level i in the master role, and cfg_data[2:0] is the identity in the slave role.
- R9: The level driven on cas_out is the one present on ack_level at the first ack rise. Later changes of ack_level during the sequence do not alter it.
- R10: Whenever cas_oe is 0, cas_out is 0. Whenever data_oe is 0, data_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| role_master | input | 1 | Role strap: 1 = master, 0 = slave |
| long_seq | input | 1 | 1 = three-pulse acknowledge sequence, 0 = two-pulse |
| ack | input | 1 | Acknowledge pulse from the CPU side, active high |
| ack_level | input | 3 | Level chosen by the priority logic, taken at the first pulse |
| vec_in | input | 8 | Vector that this controller supplies when selected |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Attachment mask (master) or identity in bits 2:0 (slave) |
| cas_in | input | 3 | Cascade lines as seen from the bus |
| cas_out | output | 3 | Value this block drives onto the cascade lines |
| cas_oe | output | 1 | Cascade drive enable |
| data_out | output | 8 | Vector toward the data bus |
| data_oe | output | 1 | Data bus drive enable |

## Verification
The bench sweeps every level under four attachment masks in both sequence lengths, and in the slave role every identity against every cascade value. A design that decoded the mask bit in the wrong position, or compared the identity bit by bit wrongly, would put the vector on the wrong controller. The bench checks the release of the cascade lines at the falling edge of the final pulse. Releasing them after the second pulse in three-pulse mode, or never releasing them, shows up as a wrong cas_oe. It also changes ack_level after the first pulse, so a design that failed to latch the level would show a moving cascade ID. Any data enable during the first pulse would also be caught.

// File: rtl/cas_sel_pkg.sv
package cas_sel_pkg;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    localparam int PIDX_W = 2;

    typedef logic [PIDX_W-1:0] pidx_t;

    // Sequencer state: pulse index (0 = idle) and the latched length
    typedef struct packed {
        logic  ack_q;
        pidx_t idx;
        pidx_t len;
    } seq_t;

    function automatic pidx_t seq_len(input logic long_mode);
        return long_mode ? pidx_t'(3) : pidx_t'(2);
    endfunction

    function automatic logic vector_pulse(input pidx_t idx);
        return idx >= pidx_t'(2);
    endfunction

endpackage

// File: rtl/cas_ack_seq.sv
module cas_ack_seq
    import cas_sel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ack,
    input  logic  long_seq,
    output logic  ack_q,
    output pidx_t pulse_idx,
    output logic  start
);

    seq_t st_q;
    logic rise;
    logic fall;

    assign rise  = ack && !st_q.ack_q;
    assign fall  = !ack && st_q.ack_q;
    assign start = rise && (st_q.idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.ack_q <= ack;
            if (start) begin
                st_q.idx <= pidx_t'(1);
                st_q.len <= seq_len(long_seq);
            end else if (rise && (st_q.idx != st_q.len)) begin
                st_q.idx <= st_q.idx + pidx_t'(1);
            end else if (fall && (st_q.idx == st_q.len)) begin
                st_q.idx <= '0;
            end
        end
    end

    assign ack_q     = st_q.ack_q;
    assign pulse_idx = st_q.idx;

endmodule

// File: rtl/cas_cfg_regs.sv
module cas_cfg_regs #(
    parameter int N_LEVELS = 8,
    parameter int ID_W     = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [N_LEVELS-1:0] cfg_data,
    output logic [N_LEVELS-1:0] attach_q,
    output logic [ID_W-1:0]     id_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            attach_q <= '0;
            id_q     <= '0;
        end else if (cfg_we) begin
            attach_q <= cfg_data;
            id_q     <= cfg_data[ID_W-1:0];
        end
    end

endmodule

// File: rtl/cas_master_drv.sv
module cas_master_drv
    import cas_sel_pkg::*;
#(
    parameter int N_LEVELS = 8,
    parameter int ID_W     = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                is_master,
    input  logic                start,
    input  logic [ID_W-1:0]     ack_level,
    input  logic [N_LEVELS-1:0] attach,
    input  pidx_t               pulse_idx,
    output logic                casc_q,
    output logic                cas_oe,
    output logic [ID_W-1:0]     cas_out
);

    logic [ID_W-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            casc_q <= 1'b0;
        end else if (start) begin
            lvl_q  <= ack_level;
            casc_q <= attach[ack_level];
        end
    end

    assign cas_oe  = is_master && casc_q && (pulse_idx != '0);
    assign cas_out = cas_oe ? lvl_q : '0;

endmodule

// File: rtl/cas_slave_cmp.sv
module cas_slave_cmp #(
    parameter int ID_W = 3
) (
    input  logic [ID_W-1:0] cas_in,
    input  logic [ID_W-1:0] id_q,
    output logic            id_match
);

    logic [ID_W-1:0] bit_eq;

    for (genvar b = 0; b < ID_W; b++) begin : g_bit
        assign bit_eq[b] = ~(cas_in[b] ^ id_q[b]);
    end

    assign id_match = &bit_eq;

endmodule

// File: rtl/cas_sel_top.sv
module cas_sel_top
    import cas_sel_pkg::*;
#(
    parameter  int N_LEVELS = 8,
    parameter  int DATA_W   = 8,
    localparam int ID_W     = $clog2(N_LEVELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              role_master,
    input  logic              long_seq,
    input  logic              ack,
    input  logic [ID_W-1:0]   ack_level,
    input  logic [DATA_W-1:0] vec_in,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [ID_W-1:0]   cas_in,
    output logic [ID_W-1:0]   cas_out,
    output logic              cas_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    role_e                role;
    logic                 ack_q;
    pidx_t                pulse_idx;
    logic                 start;
    logic [N_LEVELS-1:0]  attach_q;
    logic [ID_W-1:0]      id_q;
    logic                 casc_q;
    logic                 id_match;
    logic                 sel;

    assign role = role_e'(role_master);

    cas_ack_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .ack       (ack),
        .long_seq  (long_seq),
        .ack_q     (ack_q),
        .pulse_idx (pulse_idx),
        .start     (start)
    );

    cas_cfg_regs #(.N_LEVELS(N_LEVELS), .ID_W(ID_W)) cfg_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_data (cfg_data[N_LEVELS-1:0]),
        .attach_q (attach_q),
        .id_q     (id_q)
    );

    cas_master_drv #(.N_LEVELS(N_LEVELS), .ID_W(ID_W)) mst_i (
        .clk       (clk),
        .rst       (rst),
        .is_master (role == ROLE_MASTER),
        .start     (start),
        .ack_level (ack_level),
        .attach    (attach_q),
        .pulse_idx (pulse_idx),
        .casc_q    (casc_q),
        .cas_oe    (cas_oe),
        .cas_out   (cas_out)
    );

    cas_slave_cmp #(.ID_W(ID_W)) slv_i (
        .cas_in   (cas_in),
        .id_q     (id_q),
        .id_match (id_match)
    );

    // Master supplies its own vector only for non-cascaded levels
    assign sel      = (role == ROLE_MASTER) ? !casc_q : id_match;
    assign data_oe  = ack_q && vector_pulse(pulse_idx) && sel;
    assign data_out = data_oe ? vec_in : '0;

endmodule

// File: rtl/cas_sel_chk.sv
module cas_sel_chk #(
    parameter int ID_W   = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              role_master,
    input logic              ack,
    input logic [ID_W-1:0]   cas_in,
    input logic [ID_W-1:0]   id_q,
    input logic [ID_W-1:0]   cas_out,
    input logic              cas_oe,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe
);

    // R7
    slave_no_cas_chk: assert property (@(posedge clk) disable iff (rst)
        !role_master |-> !cas_oe);

    // R10
    cas_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cas_oe |-> (cas_out == '0));

    // R10
    data_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> (data_out == '0));

    // R2
    master_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (role_master && cas_oe) |-> !data_oe);

    // R9
    cas_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (cas_oe && $past(cas_oe)) |-> $stable(cas_out));

    // R4
    data_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> $past(ack));

    // R6
    slave_match_chk: assert property (@(posedge clk) disable iff (rst)
        (!role_master && data_oe) |-> (cas_in == id_q));

endmodule

bind cas_sel_top cas_sel_chk #(.ID_W(ID_W), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .role_master (role_master),
    .ack         (ack),
    .cas_in      (cas_in),
    .id_q        (id_q),
    .cas_out     (cas_out),
    .cas_oe      (cas_oe),
    .data_out    (data_out),
    .data_oe     (data_oe)
);

// File: tb/cas_sel_top_tb_top.sv
`timescale 1ns/1ps
module cas_sel_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       role_master = 1'b1;
    logic       long_seq = 1'b0;
    logic       ack = 1'b0;
    logic [2:0] ack_level = '0;
    logic [7:0] vec_in = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_data = '0;
    logic [2:0] cas_in = '0;
    logic [2:0] cas_out;
    logic       cas_oe;
    logic [7:0] data_out;
    logic       data_oe;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    cas_sel_top dut_i (
        .clk(clk), .rst(rst), .role_master(role_master), .long_seq(long_seq),
        .ack(ack), .ack_level(ack_level), .vec_in(vec_in), .cfg_we(cfg_we),
        .cfg_data(cfg_data), .cas_in(cas_in), .cas_out(cas_out), .cas_oe(cas_oe),
        .data_out(data_out), .data_oe(data_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_we = 1'b1;
        cfg_data = v;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    // Runs one acknowledge sequence; starts and ends at a falling clock edge
    task automatic run_seq(input logic m, input logic lng, input logic [2:0] lvl,
                           input logic [2:0] casv, input logic exp_casc,
                           input logic exp_vec);
        int n;
        logic [7:0] v;
        n = lng ? 3 : 2;
        v = {casv, 2'b10, lvl} ^ 8'h5A;
        role_master = m;
        long_seq = lng;
        cas_in = casv;
        vec_in = v;
        ack = 1'b1;
        ack_level = lvl;
        @(negedge clk);
        chk("R2/R7 cas_oe pulse1", 32'(cas_oe), 32'(exp_casc));
        chk("R2/R10 cas_out pulse1", 32'(cas_out), exp_casc ? 32'(lvl) : 32'd0);
        chk("R4 no data pulse1", 32'(data_oe), 32'd0);
        ack = 1'b0;
        ack_level = ~lvl;
        @(negedge clk);
        chk("R9 cas_out held", 32'(cas_out), exp_casc ? 32'(lvl) : 32'd0);
        chk("R4 no data gap", 32'(data_oe), 32'd0);
        for (int p = 2; p <= n; p++) begin
            ack = 1'b1;
            @(negedge clk);
            chk(m ? "R3 data_oe" : "R5/R6 data_oe", 32'(data_oe), 32'(exp_vec));
            chk(m ? "R3 data_out" : "R5/R6 data_out", 32'(data_out),
                exp_vec ? 32'(v) : 32'd0);
            chk("R2/R7 cas_oe vec", 32'(cas_oe), 32'(exp_casc));
            ack = 1'b0;
            @(negedge clk);
            chk("R4 data off", 32'(data_oe), 32'd0);
            chk("R2 cas release", 32'(cas_oe), (p == n) ? 32'd0 : 32'(exp_casc));
        end
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] masks [4];
        masks[0] = 8'h00; masks[1] = 8'hFF; masks[2] = 8'hA5; masks[3] = 8'h3C;
        repeat (3) @(negedge clk);
        chk("R1 cas_oe in reset", 32'(cas_oe), 32'd0);
        chk("R1 data_oe in reset", 32'(data_oe), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cas_out", 32'(cas_out), 32'd0);
        chk("R1 data_out", 32'(data_out), 32'd0);
        chk("R1 cas_oe", 32'(cas_oe), 32'd0);
        chk("R1 data_oe", 32'(data_oe), 32'd0);

        // Master sweep: R2, R3, R8 mask bit i selects level i
        for (int k = 0; k < 4; k++) begin
            write_cfg(masks[k]);
            for (int l = 0; l < 8; l++) begin
                for (int s = 0; s < 2; s++) begin
                    run_seq(1'b1, 1'(s), 3'(l), 3'(7 - l), masks[k][l], !masks[k][l]);
                end
            end
        end

        // Slave sweep: R5, R6, R7, R8 identity from cfg_data[2:0]
        for (int id = 0; id < 8; id++) begin
            write_cfg({5'(id * 3 + 1), 3'(id)});
            for (int cv = 0; cv < 8; cv++) begin
                for (int s = 0; s < 2; s++) begin
                    run_seq(1'b0, 1'(s), 3'(7 - cv), 3'(cv), 1'b0, cv == id);
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule